// File: doc/BRIEF.md
# Strobe-Driven FIFO Buffer with Status Flags

This block is a first-in first-out store (9-bit words, 2048 deep by default) that is controlled by two active-low strobes rather than a valid/ready handshake. A write starts when the write strobe falls, and the word on the input bus is stored when the strobe rises again. A read starts when the read strobe falls. The word is then driven on the output bus, with an output-enable standing in for a driven bus, until the strobe rises. Both strobes are brought into the system clock through two-flop synchronizers, and their edges are found from the synchronized levels.

Three active-low flags report the fill state. Empty and full block further reads and writes. A flag turns on at the edge that starts an access and turns off at the edge that ends the opposite access. Two flow-through modes are provided. If the read strobe is held low on an empty buffer, the next stored word is presented at once. If the write strobe is held low on a full buffer, the pending write is taken as soon as a read frees a slot.

Top module: `strobe_fifo`

## Requirements
- R1: While `rst` is high, and at the clock edge it is sampled, both pointers clear, `empty_n` is 0, `half_n` and `full_n` are 1, and `q_oe` is 0.
- R2: A write strobe that falls while `full_n` is 1 is accepted, and `din` is stored when that strobe rises. A strobe pulse (fall, then rise) made while `full_n` is 0 stores nothing.
- R3: An accepted read raises `q_oe` with the word on `q` while `rd_n` stays low, and `q_oe` drops after `rd_n` rises. A read pulse made while `empty_n` is 0 never raises `q_oe`.
- R4: Words come out in the order they were written, across any number of pointer wrap-arounds.
- R5: `half_n` goes to 0 at the write fall that raises the held-or-pending count above DEPTH/2. It returns to 1 at the read rise that brings the count to DEPTH/2 or below.
- R6: `full_n` goes to 0 at the fall of the write that takes the last free slot, before that write's rise. It returns to 1 after the next read rise.
- R7: `empty_n` goes to 0 after the read fall that takes the last stored word. It returns to 1 after the next write rise.
- R8: With `rd_n` held low on an empty buffer, a completed write pulses `empty_n` high for exactly one clock, then presents that word with `q_oe` = 1. Further writes made while `rd_n` stays low do not change `q`.
- R9: With `wr_n` held low on a full buffer, a completed read pulses `full_n` high for exactly one clock before it returns to 0. The pending word is stored at the next `wr_n` rise and is read out after the older words.
- R10: Flags and `q_oe` change at the third rising clock edge after the strobe transition that causes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Write strobe, active low |
| din | input | W | Write data, held stable across the write strobe |
| rd_n | input | 1 | Read strobe, active low |
| q | output | W | Read data, meaningful while q_oe is 1 |
| q_oe | output | 1 | Output drive enable (0 models high impedance) |
| empty_n | output | 1 | Empty flag, active low |
| half_n | output | 1 | More-than-half-full flag, active low |
| full_n | output | 1 | Full flag, active low |

## Verification
Every response to a strobe transition is due at the third rising clock edge after it: two synchronizer stages, then the counter and flag registers. The bench changes inputs on a falling clock edge and reads outputs four falling edges later. The R10 check reads the flag two falling edges and three falling edges after the transition, to confirm it has not moved early and has moved on time. The one-clock flow-through pulses are measured by counting, over eight falling edges, the samples on which the flag is inactive; the count must be exactly one. A monitor pops the reference queue at each rise of `q_oe` and compares `q` against the popped word.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;
  // Single-cycle edge pulses derived from a synchronized active-low strobe.
  typedef struct packed {
    logic fell;
    logic rose;
  } strobe_ev_t;
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge
  import strobe_fifo_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       strobe_n,
  output strobe_ev_t ev
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], strobe_n};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign ev.fell = prev_q & ~sync_q[STAGES-1];
  assign ev.rose = ~prev_q & sync_q[STAGES-1];
endmodule

// File: rtl/fifo_ram.sv
module fifo_ram #(
  parameter int W     = 9,
  parameter int DEPTH = 2048,
  parameter int AW    = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
  import strobe_fifo_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int AW    = 11,
  parameter int CW    = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  strobe_ev_t    wr_ev,
  input  strobe_ev_t    rd_ev,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic          empty_n,
  output logic          half_n,
  output logic          full_n,
  output logic          q_oe
);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  // claim: stored words plus a pending write, minus nothing until a read ends
  // avail: words committed and not yet taken by a read
  logic [CW-1:0] claim_q, avail_q, claim_d, avail_d;
  logic [AW-1:0] wptr_q, rptr_q;
  logic          wr_act_q, wr_wait_q, rd_act_q, rd_wait_q;
  logic          wr_take, wr_done, rd_take, rd_done;

  assign wr_take = (wr_ev.fell | (wr_wait_q & ~wr_ev.rose)) & ~wr_act_q & (claim_q != CAP);
  assign wr_done = wr_ev.rose & wr_act_q;
  assign rd_take = (rd_ev.fell | (rd_wait_q & ~rd_ev.rose)) & ~rd_act_q & (avail_q != '0);
  assign rd_done = rd_ev.rose & rd_act_q;

  assign claim_d = claim_q + CW'(wr_take) - CW'(rd_done);
  assign avail_d = avail_q + CW'(wr_done) - CW'(rd_take);

  always_ff @(posedge clk) begin
    if (rst) begin
      claim_q   <= '0;
      avail_q   <= '0;
      wptr_q    <= '0;
      rptr_q    <= '0;
      wr_act_q  <= 1'b0;
      wr_wait_q <= 1'b0;
      rd_act_q  <= 1'b0;
      rd_wait_q <= 1'b0;
      empty_n   <= 1'b0;
      half_n    <= 1'b1;
      full_n    <= 1'b1;
      q_oe      <= 1'b0;
    end else begin
      claim_q <= claim_d;
      avail_q <= avail_d;
      empty_n <= (avail_d != '0);
      half_n  <= ~(claim_d > HALF);
      full_n  <= (claim_d != CAP);

      if (wr_done) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      if (rd_take) rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;

      if (wr_take)         wr_act_q <= 1'b1;
      else if (wr_ev.rose) wr_act_q <= 1'b0;

      if (wr_ev.rose || wr_take) wr_wait_q <= 1'b0;
      else if (wr_ev.fell)       wr_wait_q <= 1'b1;

      if (rd_take)         rd_act_q <= 1'b1;
      else if (rd_ev.rose) rd_act_q <= 1'b0;

      if (rd_ev.rose || rd_take) rd_wait_q <= 1'b0;
      else if (rd_ev.fell)       rd_wait_q <= 1'b1;

      if (rd_take)      q_oe <= 1'b1;
      else if (rd_done) q_oe <= 1'b0;
    end
  end

  assign we    = wr_done;
  assign waddr = wptr_q;
  assign re    = rd_take;
  assign raddr = rptr_q;
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
  import strobe_fifo_pkg::*;
#(
  parameter int W           = 9,
  parameter int DEPTH       = 2048,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_n,
  input  logic [W-1:0] din,
  input  logic         rd_n,
  output logic [W-1:0] q,
  output logic         q_oe,
  output logic         empty_n,
  output logic         half_n,
  output logic         full_n
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  strobe_ev_t    wr_ev, rd_ev;
  logic          we, re;
  logic [AW-1:0] waddr, raddr;

  strobe_edge #(.STAGES(SYNC_STAGES)) u_wr_edge (
    .clk(clk), .rst(rst), .strobe_n(wr_n), .ev(wr_ev)
  );

  strobe_edge #(.STAGES(SYNC_STAGES)) u_rd_edge (
    .clk(clk), .rst(rst), .strobe_n(rd_n), .ev(rd_ev)
  );

  fifo_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .wr_ev(wr_ev), .rd_ev(rd_ev),
    .we(we), .waddr(waddr), .re(re), .raddr(raddr),
    .empty_n(empty_n), .half_n(half_n), .full_n(full_n), .q_oe(q_oe)
  );

  fifo_ram #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata(din),
    .re(re), .raddr(raddr), .rdata(q)
  );
endmodule

// File: rtl/strobe_fifo_chk.sv
module strobe_fifo_chk #(
  parameter int W = 9
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] q,
  input logic         q_oe,
  input logic         empty_n,
  input logic         half_n,
  input logic         full_n
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  always @(negedge clk) begin
    if (rst_d === 1'b1)
      AST_RESET_FLAGS: assert (!empty_n && half_n && full_n && !q_oe); // R1
  end

  AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !full_n |-> empty_n); // R6

  AST_FULL_HAS_HALF: assert property (@(posedge clk) disable iff (rst)
    !full_n |-> !half_n); // R5

  AST_EMPTY_NOT_HALF: assert property (@(posedge clk) disable iff (rst)
    !empty_n |-> half_n); // R7

  AST_BUS_HELD: assert property (@(posedge clk) disable iff (rst)
    (q_oe && $past(q_oe)) |-> $stable(q)); // R3
endmodule

bind strobe_fifo strobe_fifo_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .q(q), .q_oe(q_oe),
  .empty_n(empty_n), .half_n(half_n), .full_n(full_n)
);

// File: tb/tb_strobe_fifo.sv
module tb_strobe_fifo;
  localparam int W = 9;
  localparam int D = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_n = 1'b1;
  logic         rd_n = 1'b1;
  logic [W-1:0] din = '0;
  logic [W-1:0] q;
  logic         q_oe, empty_n, half_n, full_n;

  strobe_fifo #(.W(W), .DEPTH(D)) dut (
    .clk(clk), .rst(rst), .wr_n(wr_n), .din(din), .rd_n(rd_n),
    .q(q), .q_oe(q_oe), .empty_n(empty_n), .half_n(half_n), .full_n(full_n)
  );

  always #5 clk = ~clk;

  int           n_chk = 0;
  int           n_bad = 0;
  int           oe_rises = 0;
  int           model = 0;
  bit           done = 1'b0;
  logic         oe_prev = 1'b0;
  logic [W-1:0] exp_w;
  logic [W-1:0] exp_q[$];

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrap_up();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // scoreboard monitor: one expected word per rise of the output enable
  always @(negedge clk) begin
    if (!rst && q_oe && !oe_prev) begin
      oe_rises++;
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected word", int'(q), -1);
      else begin
        exp_w = exp_q.pop_front();
        chk(q == exp_w, "R4 order", int'(q), int'(exp_w));
      end
    end
    oe_prev = q_oe;
  end

  task automatic push_word(logic [W-1:0] d);
    din = d;
    idle(1);
    wr_n = 1'b0;
    idle(4);
    if (model < D) begin
      model++;
      exp_q.push_back(d);
    end
    wr_n = 1'b1;
    idle(4);
  endtask

  task automatic pull_word();
    rd_n = 1'b0;
    idle(4);
    if (model > 0) model--;
    rd_n = 1'b1;
    idle(4);
  endtask

  function automatic int count_of(logic v);
    return v ? 1 : 0;
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    wrap_up();
  end

  initial begin
    int snap, hi;
    // R1 reset state
    idle(3);
    chk(!empty_n && half_n && full_n && !q_oe, "R1 reset flags",
        {empty_n, half_n, full_n, q_oe}, 4'b0110);
    rst = 1'b0;
    idle(2);

    // R3 read pulse on empty gives no output
    snap = oe_rises;
    pull_word();
    chk(oe_rises == snap && !q_oe, "R3 read on empty", oe_rises, snap);
    chk(!empty_n, "R3 still empty", empty_n, 0);

    // R10 latency of empty release after a write rise
    din = 9'd5;
    idle(1);
    wr_n = 1'b0;
    idle(4);
    exp_q.push_back(9'd5);
    wr_n = 1'b1;
    idle(2);
    chk(!empty_n, "R10 not before third edge", empty_n, 0);
    idle(1);
    chk(empty_n, "R7 R10 empty released", empty_n, 1);
    idle(3);

    // R3 / R7 single read of the only word
    rd_n = 1'b0;
    idle(4);
    chk(q_oe, "R3 output driven", q_oe, 1);
    chk(!empty_n, "R7 empty after last fall", empty_n, 0);
    rd_n = 1'b1;
    idle(4);
    chk(!q_oe, "R3 output released", q_oe, 0);

    // fill with flag checks (R5, R6)
    for (int i = 0; i < D - 1; i++) begin
      push_word(W'(9'h100 + i));
      chk(half_n == ((i + 1) > D / 2 ? 1'b0 : 1'b1), "R5 half on fill", half_n, (i + 1) > D / 2 ? 0 : 1);
      chk(full_n, "R6 not yet full", full_n, 1);
    end
    din = 9'h1F0;
    idle(1);
    wr_n = 1'b0;
    idle(4);
    chk(!full_n, "R6 full before rise", full_n, 0);
    exp_q.push_back(9'h1F0);
    model++;
    wr_n = 1'b1;
    idle(4);

    // R2 pulse while full stores nothing (verified by drain below)
    din = 9'h1AA;
    idle(1);
    wr_n = 1'b0;
    idle(4);
    wr_n = 1'b1;
    idle(4);
    chk(!full_n, "R2 still full", full_n, 0);

    // R9 write flow-through
    din = 9'h155;
    idle(1);
    wr_n = 1'b0;
    idle(4);
    chk(!full_n, "R9 held write waits", full_n, 0);
    rd_n = 1'b0;
    idle(4);
    rd_n = 1'b1;
    hi = 0;
    for (int k = 0; k < 8; k++) begin
      idle(1);
      hi += count_of(full_n);
    end
    chk(hi == 1, "R9 full pulse width", hi, 1);
    chk(!full_n, "R9 full reasserted", full_n, 0);
    exp_q.push_back(9'h155);
    wr_n = 1'b1;
    idle(4);

    // drain: R5, R6, R7, R2, R4
    for (int k = 1; k <= D; k++) begin
      pull_word();
      chk(half_n == ((D - k) > D / 2 ? 1'b0 : 1'b1), "R5 half on drain", half_n, (D - k) > D / 2 ? 0 : 1);
      chk(full_n, "R6 full released", full_n, 1);
    end
    chk(!empty_n, "R7 empty after drain", empty_n, 0);
    chk(exp_q.size() == 0, "R2 R4 all words out", exp_q.size(), 0);
    snap = oe_rises;
    pull_word();
    chk(oe_rises == snap, "R2 ignored word absent", oe_rises, snap);

    // R8 read flow-through
    rd_n = 1'b0;
    idle(4);
    chk(!q_oe, "R8 held read waits", q_oe, 0);
    din = 9'h0F0;
    idle(1);
    wr_n = 1'b0;
    idle(4);
    exp_q.push_back(9'h0F0);
    wr_n = 1'b1;
    hi = 0;
    for (int k = 0; k < 8; k++) begin
      idle(1);
      hi += count_of(empty_n);
    end
    chk(hi == 1, "R8 empty pulse width", hi, 1);
    chk(q_oe && q == 9'h0F0, "R8 word presented", int'(q), 9'h0F0);
    model = 0;
    push_word(9'h033);
    chk(q == 9'h0F0, "R8 later write not flowing", int'(q), 9'h0F0);
    chk(empty_n, "R8 second word held", empty_n, 1);
    rd_n = 1'b1;
    idle(4);
    chk(!q_oe, "R8 output released", q_oe, 0);
    pull_word();

    // R4 ordering across many wraps
    for (int r = 0; r < 20; r++) begin
      for (int j = 0; j < 3; j++) push_word(W'(r * 37 + j * 11));
      for (int j = 0; j < 3; j++) pull_word();
    end
    chk(exp_q.size() == 0, "R4 wrap queue drained", exp_q.size(), 0);

    // R1 reset with content
    push_word(9'h011);
    push_word(9'h022);
    rst = 1'b1;
    idle(2);
    chk(!empty_n && half_n && full_n && !q_oe, "R1 reset clears",
        {empty_n, half_n, full_n, q_oe}, 4'b0110);
    exp_q.delete();
    model = 0;
    rst = 1'b0;
    idle(3);
    chk(!empty_n, "R1 empty after reset", empty_n, 0);

    wrap_up();
  end
endmodule